// File: doc/BRIEF.md
# Address-Carried Unlock Sequence Gate

This block keeps the command windows of a serial-bus controller closed until software has written a fixed six-byte key. The key is not carried on the data bus. Each key byte travels in bits [9:2] of the address of a bus access that falls in the lowest 1 kB of the controller region, which is the key window. The gate follows the writes to that window one at a time. After the sixth correct byte it raises an enable, and the decoders of the other command windows use that enable.

A wrong byte in the key window clears the enable on the next clock, and this also happens when the gate is already open. A wrong byte of 0xFF counts as the first key byte, so matching carries on from the second position. Reads of the key window return a fixed 16-bit signature on the cycle after the access. Accesses outside the key window do not affect the gate.

Top module: `magic_unlock_gate`

## Requirements
- R1: While reset is high and on the first cycle after it, `unlock_en` is 0 and `rd_data` is 0. The key position is 0.
- R2: A write to the key window takes its key byte from `addr[9:2]`. `addr[1:0]` has no effect on matching.
- R3: The key is 0xFF, 0x00, 0x55, 0xAA, 0xC1, 0xAD, in that order. On the clock after the key-window write that completes the key, `unlock_en` is 1 and the key position returns to 0.
- R4: A key-window write that matches the expected byte but does not complete the key leaves `unlock_en` unchanged.
- R5: A key-window write whose byte differs from the expected byte sets `unlock_en` to 0 on the next clock, including when it was 1.
- R6: A wrong byte equal to 0xFF sets the key position to 1, so 0xFF, 0xFF, 0x00, 0x55, 0xAA, 0xC1, 0xAD unlocks. Any other wrong byte sets the key position to 0.
- R7: An access is in the key window only when `addr[17:10]` is 0. An access outside the window changes neither `unlock_en` nor the key position.
- R8: A read (`strobe` high, `write` low) in the key window gives `rd_data` = 0xC1AD on the next clock. On any other cycle `rd_data` is 0. Reads do not change the key position.
- R9: Once the gate is open, writing the complete key again in order keeps `unlock_en` at 1 throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 18 | Byte offset of the access inside the controller region |
| strobe | input | 1 | Access valid in this cycle |
| write | input | 1 | 1 = write access, 0 = read access |
| unlock_en | output | 1 | Registered enable for the command windows |
| rd_data | output | 16 | Registered read data of the key window |

## Verification
The key position cannot be seen at the ports, so the hardest cases are the ones where that hidden position must be correct even though `unlock_en` does not change. Examples are a restart at position 1 after a stray 0xFF, position 0 after a completed key, and a key sequence interrupted by reads and by writes outside the window. The stimulus reaches these cases through key sequences that are broken and then resumed. The only way the hidden position shows is whether the rest of the key then opens the gate. A behavioural model runs in lock-step and checks the enable and the read data on every clock.

// File: rtl/unlock_pkg.sv
package unlock_pkg;

  localparam int KEY_LEN = 6;
  localparam int KEY_W   = 8;

  function automatic logic [KEY_W-1:0] key_byte(input int idx);
    case (idx)
      0:       key_byte = 8'hFF;
      1:       key_byte = 8'h00;
      2:       key_byte = 8'h55;
      3:       key_byte = 8'hAA;
      4:       key_byte = 8'hC1;
      5:       key_byte = 8'hAD;
      default: key_byte = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/unlock_decode.sv
module unlock_decode #(
  parameter int ADDR_W  = 18,
  parameter int WIN_W   = 10,
  parameter int KEY_LSB = 2,
  parameter int KEY_W   = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              strobe,
  input  logic              write,
  output logic              wr_hit,
  output logic              rd_hit,
  output logic              miss,
  output logic [KEY_W-1:0]  key
);
  localparam int HI_W = ADDR_W - WIN_W;

  logic in_win;

  always_comb begin
    in_win = (addr[ADDR_W-1:WIN_W] == HI_W'(0));
    wr_hit = strobe && write && in_win;
    rd_hit = strobe && !write && in_win;
    miss   = strobe && !in_win;
    key    = addr[KEY_LSB +: KEY_W];
  end

endmodule

// File: rtl/unlock_seq.sv
module unlock_seq
  import unlock_pkg::*;
#(
  parameter int LEN = KEY_LEN
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_hit,
  input  logic             miss,
  input  logic [KEY_W-1:0] key,
  output logic             en
);
  localparam int SW = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [SW-1:0] LAST = SW'(LEN - 1);

  logic [SW-1:0]    pos;
  logic [KEY_W-1:0] expect_b;
  logic             match;

  always_comb begin
    expect_b = key_byte(int'(pos));
    match    = (key == expect_b);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos <= '0;
      en  <= 1'b0;
    end else if (wr_hit) begin
      if (match) begin
        if (pos == LAST) begin
          pos <= '0;
          en  <= 1'b1;
        end else begin
          pos <= pos + SW'(1);
        end
      end else begin
        en  <= 1'b0;
        pos <= (key == key_byte(0)) ? SW'(1) : '0;
      end
    end
  end

  // R1: position never leaves the key range
  a_r1_pos_range: assert property (@(posedge clk) disable iff (rst) pos <= LAST);
  // R5: wrong byte closes the gate
  a_r5_mismatch_locks: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && !match) |=> !en);
  // R6: wrong 0xFF resumes at position 1
  a_r6_ff_restart: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && !match && key == 8'hFF) |=> pos == SW'(1));
  // R3: gate opens only after the final key byte
  a_r3_open_on_last: assert property (@(posedge clk) disable iff (rst)
    $rose(en) |-> $past(wr_hit && match && pos == LAST));
  // R7: outside accesses leave state alone
  a_r7_outside_stable: assert property (@(posedge clk) disable iff (rst)
    miss |=> ($stable(en) && $stable(pos)));

endmodule

// File: rtl/unlock_rdata.sv
module unlock_rdata #(
  parameter int          DATA_W = 16,
  parameter logic [15:0] SIG    = 16'hC1AD
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_hit,
  output logic [DATA_W-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_hit ? DATA_W'(SIG) : '0;
  end

  // R8: signature follows a window read
  a_r8_read_sig: assert property (@(posedge clk) disable iff (rst)
    rd_hit |=> rd_data == DATA_W'(SIG));
  a_r8_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !rd_hit |=> rd_data == '0);

endmodule

// File: rtl/magic_unlock_gate.sv
module magic_unlock_gate
  import unlock_pkg::*;
#(
  parameter int          ADDR_W  = 18,
  parameter int          WIN_W   = 10,
  parameter int          KEY_LSB = 2,
  parameter int          DATA_W  = 16,
  parameter logic [15:0] SIG     = 16'hC1AD
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              strobe,
  input  logic              write,
  output logic              unlock_en,
  output logic [DATA_W-1:0] rd_data
);
  logic             wr_hit;
  logic             rd_hit;
  logic             miss;
  logic [KEY_W-1:0] key;

  unlock_decode #(
    .ADDR_W(ADDR_W), .WIN_W(WIN_W), .KEY_LSB(KEY_LSB), .KEY_W(KEY_W)
  ) u_dec (
    .addr(addr), .strobe(strobe), .write(write),
    .wr_hit(wr_hit), .rd_hit(rd_hit), .miss(miss), .key(key)
  );

  unlock_seq #(.LEN(KEY_LEN)) u_seq (
    .clk(clk), .rst(rst), .wr_hit(wr_hit), .miss(miss), .key(key), .en(unlock_en)
  );

  unlock_rdata #(.DATA_W(DATA_W), .SIG(SIG)) u_rd (
    .clk(clk), .rst(rst), .rd_hit(rd_hit), .rd_data(rd_data)
  );

  // R8: reads never move the enable
  a_r8_read_keeps_en: assert property (@(posedge clk) disable iff (rst)
    (strobe && !write) |=> $stable(unlock_en));

endmodule

// File: tb/test_magic_unlock_gate.sv
module test_magic_unlock_gate;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [17:0] addr = '0;
  logic        strobe = 1'b0;
  logic        write = 1'b0;
  logic        unlock_en;
  logic [15:0] rd_data;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  int   m_pos = 0;
  bit   m_en = 0;
  logic [15:0] m_rd = '0;
  byte unsigned key_q[$] = '{8'hFF, 8'h00, 8'h55, 8'hAA, 8'hC1, 8'hAD};

  always #4 clk = ~clk;

  magic_unlock_gate i_magic_unlock_gate (
    .clk(clk), .rst(rst), .addr(addr), .strobe(strobe), .write(write),
    .unlock_en(unlock_en), .rd_data(rd_data)
  );

  task automatic compare(input string tag);
    checks++;
    if (unlock_en !== m_en) begin
      errors++;
      $display("FAIL %s unlock_en actual=%0b expected=%0b", tag, unlock_en, m_en);
    end
    checks++;
    if (rd_data !== m_rd) begin
      errors++;
      $display("FAIL %s rd_data actual=%h expected=%h", tag, rd_data, m_rd);
    end
  endtask

  task automatic cyc(input logic [17:0] a, input logic s, input logic w, input string tag);
    int b;
    @(negedge clk);
    addr = a; strobe = s; write = w;
    b = (int'(a) >> 2) & 255;
    m_rd = 16'h0000;
    if (s && (a >> 10) == 0) begin
      if (w) begin
        if (b == int'(key_q[m_pos])) begin
          if (m_pos == 5) begin m_en = 1; m_pos = 0; end
          else m_pos++;
        end else begin
          m_en = 0;
          m_pos = (b == 255) ? 1 : 0;
        end
      end else begin
        m_rd = 16'hC1AD;
      end
    end
    @(posedge clk);
    #2;
    compare(tag);
    strobe = 1'b0;
  endtask

  task automatic wkey(input byte unsigned b, input logic [1:0] lo, input string tag);
    cyc({8'h00, b, lo}, 1'b1, 1'b1, tag);
  endtask

  task automatic full_key(input string tag);
    foreach (key_q[i]) wkey(key_q[i], 2'b00, tag);
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    compare("R1");
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #2;
    compare("R1");
    // R4: partial key keeps gate closed
    wkey(8'hFF, 2'b00, "R4"); wkey(8'h00, 2'b00, "R4"); wkey(8'h55, 2'b00, "R4");
    // R3: remaining bytes open it
    wkey(8'hAA, 2'b00, "R3"); wkey(8'hC1, 2'b00, "R3"); wkey(8'hAD, 2'b00, "R3");
    // R8: signature read and idle
    cyc(18'h00010, 1'b1, 1'b0, "R8");
    cyc(18'h00000, 1'b0, 1'b0, "R8");
    // R7: outside write with a wrong byte does nothing
    cyc({8'h01, 8'h12, 2'b00}, 1'b1, 1'b1, "R7");
    cyc({8'hFF, 8'h12, 2'b00}, 1'b1, 1'b0, "R7");
    // R9: rerun key while open, then a single 0xFF keeps it open (position back at 0)
    full_key("R9");
    wkey(8'hFF, 2'b00, "R9");
    // R5: wrong byte while open closes it
    wkey(8'h12, 2'b00, "R5");
    // R2: low address bits ignored
    foreach (key_q[i]) wkey(key_q[i], 2'(i + 1), "R2");
    // R5: wrong byte mid-key when open
    wkey(8'hFF, 2'b00, "R5"); wkey(8'h01, 2'b00, "R5");
    // R6: stray 0xFF restarts at position 1
    wkey(8'hFF, 2'b00, "R6"); wkey(8'h00, 2'b00, "R6"); wkey(8'hFF, 2'b00, "R6");
    wkey(8'h00, 2'b00, "R6"); wkey(8'h55, 2'b00, "R6"); wkey(8'hAA, 2'b00, "R6");
    wkey(8'hC1, 2'b00, "R6"); wkey(8'hAD, 2'b00, "R6");
    // R6: other wrong byte restarts at 0; a single missing 0xFF leaves it closed
    wkey(8'h33, 2'b00, "R6");
    wkey(8'h00, 2'b00, "R6"); wkey(8'h55, 2'b00, "R6");
    // R7 and R8: key interrupted by outside writes and reads still completes
    wkey(8'hFF, 2'b00, "R7"); wkey(8'h00, 2'b00, "R7");
    cyc({8'h02, 8'h77, 2'b00}, 1'b1, 1'b1, "R7");
    cyc(18'h00004, 1'b1, 1'b0, "R8");
    wkey(8'h55, 2'b00, "R7"); wkey(8'hAA, 2'b00, "R7");
    cyc({8'h80, 8'h00, 2'b00}, 1'b1, 1'b0, "R8");
    wkey(8'hC1, 2'b00, "R7"); wkey(8'hAD, 2'b00, "R7");
    // R1: reset closes the gate and clears position
    @(negedge clk); rst = 1'b1;
    m_en = 0; m_pos = 0; m_rd = '0;
    @(posedge clk); #2;
    compare("R1");
    @(negedge clk); rst = 1'b0;
    wkey(8'h00, 2'b00, "R1");
    full_key("R3");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule